// File: doc/BRIEF.md
# Downstream Port Status and Command Register

This block holds the status of one downstream port of a USB host root hub. It also decodes the commands that software issues by writing to that status word. One bus write carries commands: a 1 in a command bit performs an action, and a 0 does nothing. Several bit positions mean one thing when read and another when written.

The block follows the attach state and the speed of the device on the port. It keeps a sticky change flag that tells software to look at the connection again. It also owns port power, which is moved by per-port commands or by hub-wide commands, depending on the switching mode and a per-port mask. Enable, suspend and reset are plain flags. Line signalling and reset timing belong to other logic.

There are three state machines:
- Power: `PWR_OFF` and `PWR_ON`. The transition power-up is taken on an accepted set command with no clear and no overcurrent. Power-down is taken on overcurrent or an accepted clear.
- Link: `LINK_DETACHED` and `LINK_ATTACHED`. Attach is taken on an attach event while power stays on. Detach is taken on a detach event or on power going off.
- Change flag: `CHG_IDLE` and `CHG_PENDING`. Raise is taken on any set request. Acknowledge is taken on a write of 1 to bit 16 when no set request arrives in the same cycle.

A parameter `SWITCHED` selects whether port power can be switched at all.

Top module: `rhp_port_status`

## Requirements
- R1: A synchronous active-high reset clears every state bit, so the read value is 0. When `SWITCHED` is 0, bit 8 still reads 1 during and after reset.
- R2: Read bits 3, 5 to 7, 10 to 15 and 17 upward always read 0.
- R3: An attach event while power is on and the port is detached sets bit 0 (connected) and latches the low-speed input into bit 9 (1 = low speed). An attach event while power is off is ignored. A detach event clears bits 0 and 9.
- R4: Bit 16 (change flag) sets on every accepted attach or detach event while `removable` is 0. Writing 1 to bit 16 clears it, and writing 0 leaves it as it is. If a set request and a clear happen in the same cycle, the flag stays set.
- R5: A write with bit 1, bit 2 or bit 4 at 1 while bit 0 reads 0 sets the change flag and sets none of the port flags.
- R6: While `removable` is 1, attach and detach events do not set the change flag. A `hub_rst_done` pulse while the port is connected does set it.
- R7: Writing 1 to bit 8 is the per-port power-on command, and writing 1 to bit 9 is the per-port power-off command. Writing 0 to either bit has no effect. Read bit 8 is the power state.
- R8: With `per_port_mode` at 0, or with `per_port_mode` at 1 and `port_pwr_mask` at 0, only `glob_pwr_set` and `glob_pwr_clr` move power. With both at 1, only the per-port write commands move it.
- R9: Overcurrent turns power off and overrides any set. When a clear and a set reach power in the same cycle, power ends up off.
- R10: In the cycle where bit 8 reads 0, bits 0, 1, 2, 4 and 9 also read 0.
- R11: When `SWITCHED` is 0, bit 8 and `port_pwr_en` are always 1, whatever the commands or overcurrent.
- R12: `port_pwr_en` always equals read bit 8.
- R13: While the port is connected, a write of 1 to bit 1, bit 2 or bit 4 sets the enable, suspend or reset flag, read at those same bits. A write of 1 to bit 0 clears enable, and a write of 1 to bit 3 clears suspend. All three flags clear on detach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | DATA_W | Write data; 1 bits are commands |
| attach_evt | input | 1 | Device attach event pulse |
| detach_evt | input | 1 | Device detach event pulse |
| low_speed_in | input | 1 | Speed of the attaching device (1 = low) |
| over_current | input | 1 | Overcurrent condition |
| glob_pwr_set | input | 1 | Hub-wide power-on command |
| glob_pwr_clr | input | 1 | Hub-wide power-off command |
| per_port_mode | input | 1 | 1 = per-port power switching |
| port_pwr_mask | input | 1 | Per-port mask bit for this port |
| removable | input | 1 | Device is non-removable; events are reported after hub reset |
| hub_rst_done | input | 1 | Pulse at the end of a hub-wide reset |
| rd_data | output | DATA_W | Status read value |
| port_pwr_en | output | 1 | Port power switch enable |

## Verification
The change-flag race is the hardest case to reach from the ports. It needs an attach event in the same cycle as a write of 1 to bit 16, arriving while the flag is already pending. The stimulus first leaves a detach unacknowledged, then issues both in one cycle, and checks that the flag survives.

Power loss through overcurrent is reached with the port connected and enabled. A hub-wide set is asserted in the same cycle, so the stimulus shows overcurrent winning and the link flags dropping together with power. A second instance built with switching off shares all inputs, and its power bit is compared on every cycle.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

    // bit positions decoded by software; fixed by behaviour
    localparam int unsigned POS_CONN     = 0;
    localparam int unsigned POS_EN       = 1;
    localparam int unsigned POS_SUSP     = 2;
    localparam int unsigned POS_SUSP_CLR = 3;
    localparam int unsigned POS_PRST     = 4;
    localparam int unsigned POS_PWR      = 8;
    localparam int unsigned POS_LS       = 9;
    localparam int unsigned POS_CHG      = 16;
    localparam int unsigned MIN_WIDTH    = POS_CHG + 1;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    typedef enum logic {
        LINK_DETACHED = 1'b0,
        LINK_ATTACHED = 1'b1
    } link_state_e;

    typedef enum logic {
        CHG_IDLE    = 1'b0,
        CHG_PENDING = 1'b1
    } chg_state_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic set_susp;
        logic clr_susp;
        logic set_prst;
        logic set_pwr;
        logic clr_pwr;
        logic clr_chg;
    } cmd_t;

endpackage

// File: rtl/rhp_cmd_decode.sv
module rhp_cmd_decode
    import rhp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            cmd.clr_en   = wr_data[POS_CONN];
            cmd.set_en   = wr_data[POS_EN];
            cmd.set_susp = wr_data[POS_SUSP];
            cmd.clr_susp = wr_data[POS_SUSP_CLR];
            cmd.set_prst = wr_data[POS_PRST];
            cmd.set_pwr  = wr_data[POS_PWR];
            cmd.clr_pwr  = wr_data[POS_LS];
            cmd.clr_chg  = wr_data[POS_CHG];
        end
    end

endmodule

// File: rtl/rhp_power_ctl.sv
module rhp_power_ctl
    import rhp_pkg::*;
#(
    parameter bit SWITCHED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic port_set,
    input  logic port_clr,
    input  logic glob_set,
    input  logic glob_clr,
    input  logic over_current,
    input  logic per_port_mode,
    input  logic port_mask,
    output logic pwr_on,
    output logic pwr_on_nxt
);

    generate
        if (SWITCHED) begin : g_switched
            pwr_state_e st_q, st_d;
            logic       use_port;
            logic       do_set;
            logic       do_clr;

            assign use_port = per_port_mode & port_mask;
            assign do_set   = use_port ? port_set : glob_set;
            assign do_clr   = use_port ? port_clr : glob_clr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= PWR_OFF;
                end else begin
                    st_q <= st_d;
                end
            end

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    PWR_OFF: begin
                        if (do_set && !do_clr && !over_current) begin
                            st_d = PWR_ON;
                        end
                    end
                    PWR_ON: begin
                        if (over_current || do_clr) begin
                            st_d = PWR_OFF;
                        end
                    end
                    default: st_d = PWR_OFF;
                endcase
            end

            assign pwr_on     = (st_q == PWR_ON);
            assign pwr_on_nxt = (st_d == PWR_ON);
        end else begin : g_fixed
            logic unused_pwr_inputs;
            assign unused_pwr_inputs = ^{clk, rst, port_set, port_clr, glob_set,
                                         glob_clr, over_current, per_port_mode,
                                         port_mask};
            assign pwr_on     = 1'b1;
            assign pwr_on_nxt = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rhp_link_track.sv
module rhp_link_track
    import rhp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_on_nxt,
    input  logic attach_evt,
    input  logic detach_evt,
    input  logic low_speed_in,
    input  cmd_t cmd,
    output logic conn,
    output logic en,
    output logic susp,
    output logic prst,
    output logic low_speed,
    output logic attach_ok,
    output logic detach_ok
);

    link_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LINK_DETACHED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        attach_ok = 1'b0;
        detach_ok = 1'b0;
        unique case (st_q)
            LINK_DETACHED: begin
                if (attach_evt && pwr_on_nxt) begin
                    st_d      = LINK_ATTACHED;
                    attach_ok = 1'b1;
                end
            end
            LINK_ATTACHED: begin
                if (detach_evt) begin
                    detach_ok = 1'b1;
                end
                if (detach_evt || !pwr_on_nxt) begin
                    st_d = LINK_DETACHED;
                end
            end
            default: st_d = LINK_DETACHED;
        endcase
    end

    // flags: cleared whenever the link is (or becomes) detached
    always_ff @(posedge clk) begin
        if (rst || st_d == LINK_DETACHED) begin
            en        <= 1'b0;
            susp      <= 1'b0;
            prst      <= 1'b0;
            low_speed <= 1'b0;
        end else begin
            if (attach_ok) begin
                low_speed <= low_speed_in;
            end
            if (cmd.clr_en) begin
                en <= 1'b0;
            end else if (conn && cmd.set_en) begin
                en <= 1'b1;
            end
            if (cmd.clr_susp) begin
                susp <= 1'b0;
            end else if (conn && cmd.set_susp) begin
                susp <= 1'b1;
            end
            if (conn && cmd.set_prst) begin
                prst <= 1'b1;
            end
        end
    end

    assign conn = (st_q == LINK_ATTACHED);

endmodule

// File: rtl/rhp_change_flag.sv
module rhp_change_flag
    import rhp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic removable,
    input  logic conn,
    input  logic attach_ok,
    input  logic detach_ok,
    input  logic hub_rst_done,
    input  cmd_t cmd,
    output logic chg
);

    chg_state_e st_q, st_d;
    logic       evt_req;
    logic       late_req;
    logic       stale_req;
    logic       set_req;

    assign evt_req   = !removable && (attach_ok || detach_ok);
    assign late_req  = removable && hub_rst_done && conn;
    assign stale_req = !conn && (cmd.set_en || cmd.set_susp || cmd.set_prst);
    assign set_req   = evt_req || late_req || stale_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CHG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CHG_IDLE: begin
                if (set_req) begin
                    st_d = CHG_PENDING;
                end
            end
            CHG_PENDING: begin
                if (cmd.clr_chg && !set_req) begin
                    st_d = CHG_IDLE;
                end
            end
            default: st_d = CHG_IDLE;
        endcase
    end

    assign chg = (st_q == CHG_PENDING);

endmodule

// File: rtl/rhp_port_status.sv
module rhp_port_status
    import rhp_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter bit          SWITCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              attach_evt,
    input  logic              detach_evt,
    input  logic              low_speed_in,
    input  logic              over_current,
    input  logic              glob_pwr_set,
    input  logic              glob_pwr_clr,
    input  logic              per_port_mode,
    input  logic              port_pwr_mask,
    input  logic              removable,
    input  logic              hub_rst_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              port_pwr_en
);

    localparam bit WIDTH_OK = (DATA_W >= MIN_WIDTH);

    generate
        if (!WIDTH_OK) begin : g_bad_width
            initial $error("DATA_W too small for status layout");
        end
    endgenerate

    cmd_t cmd;
    logic pwr_on;
    logic pwr_on_nxt;
    logic conn;
    logic en;
    logic susp;
    logic prst;
    logic low_speed;
    logic attach_ok;
    logic detach_ok;
    logic chg;

    rhp_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    rhp_power_ctl #(.SWITCHED(SWITCHED)) u_pwr (
        .clk           (clk),
        .rst           (rst),
        .port_set      (cmd.set_pwr),
        .port_clr      (cmd.clr_pwr),
        .glob_set      (glob_pwr_set),
        .glob_clr      (glob_pwr_clr),
        .over_current  (over_current),
        .per_port_mode (per_port_mode),
        .port_mask     (port_pwr_mask),
        .pwr_on        (pwr_on),
        .pwr_on_nxt    (pwr_on_nxt)
    );

    rhp_link_track u_link (
        .clk          (clk),
        .rst          (rst),
        .pwr_on_nxt   (pwr_on_nxt),
        .attach_evt   (attach_evt),
        .detach_evt   (detach_evt),
        .low_speed_in (low_speed_in),
        .cmd          (cmd),
        .conn         (conn),
        .en           (en),
        .susp         (susp),
        .prst         (prst),
        .low_speed    (low_speed),
        .attach_ok    (attach_ok),
        .detach_ok    (detach_ok)
    );

    rhp_change_flag u_chg (
        .clk          (clk),
        .rst          (rst),
        .removable    (removable),
        .conn         (conn),
        .attach_ok    (attach_ok),
        .detach_ok    (detach_ok),
        .hub_rst_done (hub_rst_done),
        .cmd          (cmd),
        .chg          (chg)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[POS_CONN] = conn;
        rd_data[POS_EN]   = en;
        rd_data[POS_SUSP] = susp;
        rd_data[POS_PRST] = prst;
        rd_data[POS_PWR]  = pwr_on;
        rd_data[POS_LS]   = low_speed;
        rd_data[POS_CHG]  = chg;
    end

    assign port_pwr_en = pwr_on;

endmodule

// File: rtl/rhp_port_status_chk.sv
module rhp_port_status_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter bit          SWITCHED = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              detach_evt,
    input logic              over_current,
    input logic              removable,
    input logic [DATA_W-1:0] rd_data,
    input logic              port_pwr_en
);

    localparam logic [DATA_W-1:0] LIVE_MASK =
        DATA_W'((1 << 0) | (1 << 1) | (1 << 2) | (1 << 4) |
                (1 << 8) | (1 << 9) | (1 << 16));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    // R12
    pwr_pin_chk: assert property (@(posedge clk) disable iff (rst)
        port_pwr_en == rd_data[8]);

    // R10
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[8] |-> (rd_data[0] | rd_data[1] | rd_data[2] | rd_data[4] | rd_data[9]) == 1'b0);

    // R9
    ovc_off_chk: assert property (@(posedge clk) disable iff (rst)
        (over_current && SWITCHED) |=> !rd_data[8]);

    // R11
    fixed_on_chk: assert property (@(posedge clk) disable iff (rst)
        !SWITCHED |-> rd_data[8]);

    // R4
    detach_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (detach_evt && rd_data[0] && !removable) |=> rd_data[16]);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[16] && !(wr_en && wr_data[16])) |=> rd_data[16]);

endmodule

bind rhp_port_status rhp_port_status_chk #(
    .DATA_W   (DATA_W),
    .SWITCHED (SWITCHED)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .detach_evt   (detach_evt),
    .over_current (over_current),
    .removable    (removable),
    .rd_data      (rd_data),
    .port_pwr_en  (port_pwr_en)
);

// File: tb/rhp_port_status_tb_top.sv
module rhp_port_status_tb_top;

    localparam int unsigned W = 32;
    localparam logic [W-1:0] CCS = 32'h1;
    localparam logic [W-1:0] PES = 32'h2;
    localparam logic [W-1:0] PSS = 32'h4;
    localparam logic [W-1:0] PRS = 32'h10;
    localparam logic [W-1:0] PPS = 32'h100;
    localparam logic [W-1:0] LSD = 32'h200;
    localparam logic [W-1:0] CSC = 32'h10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic attach_evt = 1'b0;
    logic detach_evt = 1'b0;
    logic low_speed_in = 1'b0;
    logic over_current = 1'b0;
    logic glob_pwr_set = 1'b0;
    logic glob_pwr_clr = 1'b0;
    logic per_port_mode = 1'b0;
    logic port_pwr_mask = 1'b0;
    logic removable = 1'b0;
    logic hub_rst_done = 1'b0;
    logic [W-1:0] rd_data;
    logic port_pwr_en;
    logic [W-1:0] ns_rd_data;
    logic ns_pwr_en;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] rd;
        string        req;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;

    rhp_port_status #(.DATA_W(W), .SWITCHED(1'b1)) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .attach_evt (attach_evt), .detach_evt (detach_evt),
        .low_speed_in (low_speed_in), .over_current (over_current),
        .glob_pwr_set (glob_pwr_set), .glob_pwr_clr (glob_pwr_clr),
        .per_port_mode (per_port_mode), .port_pwr_mask (port_pwr_mask),
        .removable (removable), .hub_rst_done (hub_rst_done),
        .rd_data (rd_data), .port_pwr_en (port_pwr_en)
    );

    rhp_port_status #(.DATA_W(W), .SWITCHED(1'b0)) dut_fixed_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .attach_evt (attach_evt), .detach_evt (detach_evt),
        .low_speed_in (low_speed_in), .over_current (over_current),
        .glob_pwr_set (glob_pwr_set), .glob_pwr_clr (glob_pwr_clr),
        .per_port_mode (per_port_mode), .port_pwr_mask (port_pwr_mask),
        .removable (removable), .hub_rst_done (hub_rst_done),
        .rd_data (ns_rd_data), .port_pwr_en (ns_pwr_en)
    );

    // driver: one clock edge, then queue the expected read value
    task automatic tick(input logic [W-1:0] exp, input string req);
        @(posedge clk);
        #1;
        exp_q.push_back('{rd: exp, req: req});
        @(negedge clk);
        wr_en        = 1'b0;
        wr_data      = '0;
        attach_evt   = 1'b0;
        detach_evt   = 1'b0;
        glob_pwr_set = 1'b0;
        glob_pwr_clr = 1'b0;
        hub_rst_done = 1'b0;
    endtask

    task automatic wr(input logic [W-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            compared++;
            if (rd_data !== it.rd || port_pwr_en !== it.rd[8]) begin
                mismatched++;
                $display("FAIL %s (R12 pin): rd=%h pwr=%b expected rd=%h pwr=%b",
                         it.req, rd_data, port_pwr_en, it.rd, it.rd[8]);
            end
            compared++;
            if (ns_rd_data[8] !== 1'b1 || ns_pwr_en !== 1'b1) begin
                mismatched++;
                $display("FAIL R11 fixed power: bit8=%b pwr=%b expected 1 1",
                         ns_rd_data[8], ns_pwr_en);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick('0, "R1 reset");
        rst = 1'b0;
        tick('0, "R1 after reset");

        attach_evt = 1'b1; low_speed_in = 1'b1;
        tick('0, "R3 attach while unpowered");
        glob_pwr_set = 1'b1;
        tick(PPS, "R8 global set in global mode");
        wr(PPS | LSD);
        tick(PPS, "R8 port clear ignored in global mode");

        attach_evt = 1'b1; low_speed_in = 1'b1;
        tick(PPS | CCS | LSD | CSC, "R3 R4 attach low speed");
        wr('0);
        tick(PPS | CCS | LSD | CSC, "R4 write 0 keeps flag");
        wr(CSC);
        tick(PPS | CCS | LSD, "R4 write 1 clears flag");
        wr(PES | PSS | PRS);
        tick(PPS | CCS | LSD | PES | PSS | PRS, "R13 set flags");
        wr(CCS | 32'h8);
        tick(PPS | CCS | LSD | PRS, "R13 clear enable and suspend");
        detach_evt = 1'b1;
        tick(PPS | CSC, "R3 R4 R13 detach");

        attach_evt = 1'b1; low_speed_in = 1'b0; wr(CSC);
        tick(PPS | CCS | CSC, "R4 set wins over clear");
        wr(CSC);
        tick(PPS | CCS, "R4 clear");
        detach_evt = 1'b1;
        tick(PPS | CSC, "R4 detach");
        wr(CSC);
        tick(PPS, "R4 clear after detach");
        wr(PRS);
        tick(PPS | CSC, "R5 command while detached");
        wr(CSC);
        tick(PPS, "R5 clear");

        removable = 1'b1; attach_evt = 1'b1;
        tick(PPS | CCS, "R6 attach silent when removable");
        hub_rst_done = 1'b1;
        tick(PPS | CCS | CSC, "R6 flag after hub reset");
        wr(CSC);
        tick(PPS | CCS, "R6 clear");
        removable = 1'b0;

        wr(PES);
        tick(PPS | CCS | PES, "R13 enable");
        over_current = 1'b1; glob_pwr_set = 1'b1;
        tick('0, "R9 R10 overcurrent beats set");
        over_current = 1'b0; glob_pwr_set = 1'b1;
        tick(PPS, "R8 global set");
        attach_evt = 1'b1;
        tick(PPS | CCS | CSC, "R3 reattach");
        wr(CSC);
        tick(PPS | CCS, "R4 clear");

        per_port_mode = 1'b1; port_pwr_mask = 1'b1; glob_pwr_clr = 1'b1;
        tick(PPS | CCS, "R8 global clear ignored in per-port mode");
        wr(PPS | LSD);
        tick('0, "R9 R10 clear wins over set");
        wr(PPS);
        tick(PPS, "R7 port power on");
        wr('0);
        tick(PPS, "R7 write 0 no effect");

        port_pwr_mask = 1'b0; wr(LSD);
        tick(PPS, "R8 port clear ignored with mask 0");
        glob_pwr_clr = 1'b1;
        tick('0, "R8 global clear with mask 0");
        glob_pwr_set = 1'b1; glob_pwr_clr = 1'b1;
        tick('0, "R9 global clear and set");
        glob_pwr_set = 1'b1;
        tick(PPS, "R8 global set with mask 0");
        wr('1);
        tick(PPS | CSC, "R2 R5 all-ones write");

        @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule